// File: doc/BRIEF.md
# Display RAM Address Window Sequencer

This block produces the column and page address for a graphic display memory while the host streams pixel bytes into it or reads them back. The host first defines a rectangular window with separate column and page bounds. It also picks the scan orientation: which axis moves fastest, and whether each axis runs in mirrored order. A command byte then opens either a write stream or a read stream. Every data byte that follows raises one memory enable, with the current address, on the cycle after the byte is taken, and may move the pointer on to the next cell of the window.

The window and orientation settings arrive on their own decoded strobes. The byte stream arrives as a valid strobe, a data/command flag and an 8-bit value. In a read stream the first byte is a dummy fetch that does not move the pointer. After that, the pointer moves once for every two bytes read.

Top module: `dram_win_seq`

## Requirements
- R1: After the synchronous active-high reset, all outputs are zero. Both windows are 0..0, the column axis moves fastest, neither axis is mirrored, and no stream is open.
- R2: A window bound above its limit is clamped to that limit. The column limit is 32 and the page limit is 129.
- R3: A command byte (`byte_dc`=0) of value 0x5C opens a write stream. Each following data byte (`byte_dc`=1) gives a one-cycle `ram_we` on the next cycle, carrying the byte on `ram_wdata` and the address it was taken at.
- R4: With `scan_cfg[0]`=0, the column pointer steps after each write. At the column end it reloads the column start and the page steps by one. When both pointers are at their ends, the pointer returns to the window origin.
- R5: With `scan_cfg[0]`=1, the page axis is the fast axis and the column axis is the slow axis, with the same reload and wrap rules as in R4.
- R6: `scan_cfg[1]` mirrors the page address and `scan_cfg[2]` mirrors the column address. A mirrored axis outputs start+end−p, where p is its logical pointer.
- R7: A command byte 0x5D opens a read stream. The first data byte gives `ram_re` with `rd_dummy` and does not move the pointer. Later bytes each give `ram_re` at the current address, and the pointer moves after every second one.
- R8: Any other command byte closes the open stream. Data bytes that follow give no enable until a new 0x5C or 0x5D arrives. A later 0x5D starts again with a dummy byte.
- R9: Writing a window sets that axis's pointer to the new window start.
- R10: Data bytes that arrive when no stream has been opened since reset give no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_win_we | input | 1 | Load the column window |
| col_win_lo | input | COL_W | Column window start |
| col_win_hi | input | COL_W | Column window end |
| page_win_we | input | 1 | Load the page window |
| page_win_lo | input | PAGE_W | Page window start |
| page_win_hi | input | PAGE_W | Page window end |
| scan_we | input | 1 | Load the orientation bits |
| scan_cfg | input | 3 | bit0 page-first, bit1 page mirror, bit2 column mirror |
| byte_vld | input | 1 | A host byte is present |
| byte_dc | input | 1 | 1 = data byte, 0 = command byte |
| byte_val | input | 8 | Host byte value |
| ram_col | output | COL_W | Column address of the access |
| ram_page | output | PAGE_W | Page address of the access |
| ram_we | output | 1 | Memory write enable |
| ram_re | output | 1 | Memory read enable |
| ram_wdata | output | 8 | Byte to write |
| rd_dummy | output | 1 | The current read is the discarded dummy |

## Verification
The directed runs use narrow windows so that each edge case shows up in a few bytes. A single-cell default window tells a wrap from a stuck pointer. Oversize bounds tell clamping apart from truncation. A 3x2 window exposes the reload and slow-axis step in both scan orders and under each mirror bit, and a read burst shows the dummy-then-pair rhythm. The random mix then interleaves window, orientation and stream commands. It catches state that leaks across a mode change, such as a read phase surviving a command byte or a pointer not reloaded by a window write.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h5C;
  localparam logic [7:0] CMD_READ  = 8'h5D;

  localparam int SCAN_PAGE_FIRST = 0;
  localparam int SCAN_PAGE_MIRR  = 1;
  localparam int SCAN_COL_MIRR   = 2;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_WRITE = 2'd1,
    M_READ  = 2'd2
  } stream_e;

  typedef enum logic [1:0] {
    RS_DUMMY  = 2'd0,
    RS_FIRST  = 2'd1,
    RS_SECOND = 2'd2
  } rphase_e;
endpackage

// File: rtl/win_axis.sv
module win_axis #(
  parameter int MAXV = 32,
  parameter int W    = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         win_we,
  input  logic [W-1:0] win_lo,
  input  logic [W-1:0] win_hi,
  input  logic         mirror,
  input  logic         step,
  output logic         at_end,
  output logic [W-1:0] phys
);
  localparam logic [W-1:0] LIMIT = W'(MAXV);

  logic [W-1:0] lo_q, hi_q, cur_q, lo_c, hi_c;
  logic [W:0]   msum;

  always_comb begin
    lo_c   = (win_lo > LIMIT) ? LIMIT : win_lo;
    hi_c   = (win_hi > LIMIT) ? LIMIT : win_hi;
    at_end = (cur_q >= hi_q);
    msum   = {1'b0, lo_q} + {1'b0, hi_q} - {1'b0, cur_q};
    phys   = mirror ? msum[W-1:0] : cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cur_q <= '0;
    end else if (win_we) begin
      lo_q  <= lo_c;
      hi_q  <= hi_c;
      cur_q <= lo_c;
    end else if (step) begin
      cur_q <= at_end ? lo_q : cur_q + 1'b1;
    end
  end
endmodule

// File: rtl/win_mode_ctrl.sv
module win_mode_ctrl
  import dwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic       byte_dc,
  input  logic [7:0] byte_val,
  output logic       adv,
  output logic       we_req,
  output logic       re_req,
  output logic       dummy
);
  stream_e st_q, st_n;
  rphase_e rs_q, rs_n;

  always_comb begin
    adv    = 1'b0;
    we_req = 1'b0;
    re_req = 1'b0;
    dummy  = 1'b0;
    st_n   = st_q;
    rs_n   = rs_q;
    if (byte_vld) begin
      if (!byte_dc) begin
        rs_n = RS_DUMMY;
        case (byte_val)
          CMD_WRITE: st_n = M_WRITE;
          CMD_READ:  st_n = M_READ;
          default:   st_n = M_IDLE;
        endcase
      end else begin
        case (st_q)
          M_WRITE: begin
            we_req = 1'b1;
            adv    = 1'b1;
          end
          M_READ: begin
            re_req = 1'b1;
            case (rs_q)
              RS_DUMMY: begin
                dummy = 1'b1;
                rs_n  = RS_FIRST;
              end
              RS_FIRST: rs_n = RS_SECOND;
              default: begin
                adv  = 1'b1;
                rs_n = RS_FIRST;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= M_IDLE;
      rs_q <= RS_DUMMY;
    end else begin
      st_q <= st_n;
      rs_q <= rs_n;
    end
  end
endmodule

// File: rtl/dram_win_seq.sv
module dram_win_seq
  import dwin_pkg::*;
#(
  parameter int COL_MAX  = 32,
  parameter int PAGE_MAX = 129,
  parameter int COL_W    = $clog2(COL_MAX + 1),
  parameter int PAGE_W   = $clog2(PAGE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              col_win_we,
  input  logic [COL_W-1:0]  col_win_lo,
  input  logic [COL_W-1:0]  col_win_hi,
  input  logic              page_win_we,
  input  logic [PAGE_W-1:0] page_win_lo,
  input  logic [PAGE_W-1:0] page_win_hi,
  input  logic              scan_we,
  input  logic [2:0]        scan_cfg,
  input  logic              byte_vld,
  input  logic              byte_dc,
  input  logic [7:0]        byte_val,
  output logic [COL_W-1:0]  ram_col,
  output logic [PAGE_W-1:0] ram_page,
  output logic              ram_we,
  output logic              ram_re,
  output logic [7:0]        ram_wdata,
  output logic              rd_dummy
);
  logic [2:0]        scan_q;
  logic              adv, we_req, re_req, dummy;
  logic              col_end, page_end, col_step, page_step;
  logic [COL_W-1:0]  col_phys;
  logic [PAGE_W-1:0] page_phys;
  logic              page_first;

  assign page_first = scan_q[SCAN_PAGE_FIRST];
  assign col_step   = adv & (~page_first | page_end);
  assign page_step  = adv & (page_first | col_end);

  win_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_dc(byte_dc),
    .byte_val(byte_val), .adv(adv), .we_req(we_req), .re_req(re_req),
    .dummy(dummy)
  );

  win_axis #(.MAXV(COL_MAX), .W(COL_W)) u_col (
    .clk(clk), .rst(rst), .win_we(col_win_we), .win_lo(col_win_lo),
    .win_hi(col_win_hi), .mirror(scan_q[SCAN_COL_MIRR]), .step(col_step),
    .at_end(col_end), .phys(col_phys)
  );

  win_axis #(.MAXV(PAGE_MAX), .W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .win_we(page_win_we), .win_lo(page_win_lo),
    .win_hi(page_win_hi), .mirror(scan_q[SCAN_PAGE_MIRR]), .step(page_step),
    .at_end(page_end), .phys(page_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q    <= '0;
      ram_col   <= '0;
      ram_page  <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_wdata <= '0;
      rd_dummy  <= 1'b0;
    end else begin
      if (scan_we) scan_q <= scan_cfg;
      ram_we   <= we_req;
      ram_re   <= re_req;
      rd_dummy <= dummy;
      if (we_req | re_req) begin
        ram_col  <= col_phys;
        ram_page <= page_phys;
      end
      if (we_req) ram_wdata <= byte_val;
    end
  end
endmodule

// File: rtl/dram_win_seq_chk.sv
module dram_win_seq_chk #(
  parameter int COL_MAX  = 32,
  parameter int PAGE_MAX = 129,
  parameter int COL_W    = 6,
  parameter int PAGE_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              col_win_we,
  input logic [COL_W-1:0]  col_win_lo,
  input logic [COL_W-1:0]  col_win_hi,
  input logic              page_win_we,
  input logic [PAGE_W-1:0] page_win_lo,
  input logic [PAGE_W-1:0] page_win_hi,
  input logic              byte_vld,
  input logic              byte_dc,
  input logic [COL_W-1:0]  ram_col,
  input logic [PAGE_W-1:0] ram_page,
  input logic              ram_we,
  input logic              ram_re,
  input logic              rd_dummy
);
  logic [COL_W-1:0]  sc_lo, sc_hi;
  logic [PAGE_W-1:0] sp_lo, sp_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_lo <= '0; sc_hi <= '0; sp_lo <= '0; sp_hi <= '0;
    end else begin
      if (col_win_we) begin
        sc_lo <= (int'(col_win_lo) > COL_MAX) ? COL_W'(COL_MAX) : col_win_lo;
        sc_hi <= (int'(col_win_hi) > COL_MAX) ? COL_W'(COL_MAX) : col_win_hi;
      end
      if (page_win_we) begin
        sp_lo <= (int'(page_win_lo) > PAGE_MAX) ? PAGE_W'(PAGE_MAX) : page_win_lo;
        sp_hi <= (int'(page_win_hi) > PAGE_MAX) ? PAGE_W'(PAGE_MAX) : page_win_hi;
      end
    end
  end

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re)); // R3

  AST_WE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(byte_vld && byte_dc)); // R3

  AST_CMD_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $past(byte_vld && !byte_dc) |-> (!ram_we && !ram_re)); // R8

  AST_DUMMY_IS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_dummy |-> ram_re); // R7

  AST_COL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ((ram_we || ram_re) && !$past(col_win_we) && sc_lo <= sc_hi)
      |-> (ram_col >= sc_lo && ram_col <= sc_hi)); // R2

  AST_PAGE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ((ram_we || ram_re) && !$past(page_win_we) && sp_lo <= sp_hi)
      |-> (ram_page >= sp_lo && ram_page <= sp_hi)); // R6
endmodule

bind dram_win_seq dram_win_seq_chk #(
  .COL_MAX(COL_MAX), .PAGE_MAX(PAGE_MAX), .COL_W(COL_W), .PAGE_W(PAGE_W)
) u_chk (.*);

// File: tb/sim_dram_win_seq.sv
`timescale 1ns/1ps
module sim_dram_win_seq;
  localparam int CW = 6;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          col_win_we, page_win_we, scan_we, byte_vld, byte_dc;
  logic [CW-1:0] col_win_lo, col_win_hi;
  logic [PW-1:0] page_win_lo, page_win_hi;
  logic [2:0]    scan_cfg;
  logic [7:0]    byte_val;
  logic [CW-1:0] ram_col;
  logic [PW-1:0] ram_page;
  logic          ram_we, ram_re, rd_dummy;
  logic [7:0]    ram_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // bench reference state
  int m_clo, m_chi, m_plo, m_phi, m_cc, m_pc;
  int m_pf, m_pm, m_cm, m_mode, m_rs;

  always #4 clk = ~clk;

  dram_win_seq u0 (
    .clk(clk), .rst(rst), .col_win_we(col_win_we), .col_win_lo(col_win_lo),
    .col_win_hi(col_win_hi), .page_win_we(page_win_we), .page_win_lo(page_win_lo),
    .page_win_hi(page_win_hi), .scan_we(scan_we), .scan_cfg(scan_cfg),
    .byte_vld(byte_vld), .byte_dc(byte_dc), .byte_val(byte_val),
    .ram_col(ram_col), .ram_page(ram_page), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .rd_dummy(rd_dummy)
  );

  function automatic int clampv(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic int mapv(int c, int lo, int hi, int mir, int w);
    return mir ? ((lo + hi - c) & ((1 << w) - 1)) : c;
  endfunction

  task automatic model_step();
    if (!m_pf) begin
      if (m_cc >= m_chi) begin
        m_cc = m_clo;
        m_pc = (m_pc >= m_phi) ? m_plo : m_pc + 1;
      end else m_cc++;
    end else begin
      if (m_pc >= m_phi) begin
        m_pc = m_plo;
        m_cc = (m_cc >= m_chi) ? m_clo : m_cc + 1;
      end else m_pc++;
    end
  endtask

  task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_col(int lo, int hi);
    @(negedge clk);
    col_win_we = 1'b1; col_win_lo = CW'(lo); col_win_hi = CW'(hi);
    m_clo = clampv(lo, 32); m_chi = clampv(hi, 32); m_cc = m_clo;
    @(posedge clk); #2; col_win_we = 1'b0;
  endtask

  task automatic set_page(int lo, int hi);
    @(negedge clk);
    page_win_we = 1'b1; page_win_lo = PW'(lo); page_win_hi = PW'(hi);
    m_plo = clampv(lo, 129); m_phi = clampv(hi, 129); m_pc = m_plo;
    @(posedge clk); #2; page_win_we = 1'b0;
  endtask

  task automatic set_scan(int cfg);
    @(negedge clk);
    scan_we = 1'b1; scan_cfg = 3'(cfg);
    m_pf = cfg & 1; m_pm = (cfg >> 1) & 1; m_cm = (cfg >> 2) & 1;
    @(posedge clk); #2; scan_we = 1'b0;
  endtask

  task automatic send(bit dc, logic [7:0] v, string tag);
    logic ew, er, ed;
    int   ecol, epage;
    logic [24:0] act, exp;
    ew = 0; er = 0; ed = 0;
    ecol = mapv(m_cc, m_clo, m_chi, m_cm, CW);
    epage = mapv(m_pc, m_plo, m_phi, m_pm, PW);
    if (!dc) begin
      m_rs = 0;
      m_mode = (v == 8'h5C) ? 1 : (v == 8'h5D) ? 2 : 0;
    end else if (m_mode == 1) begin
      ew = 1; model_step();
    end else if (m_mode == 2) begin
      er = 1;
      if (m_rs == 0) begin ed = 1; m_rs = 1; end
      else if (m_rs == 1) m_rs = 2;
      else begin model_step(); m_rs = 1; end
    end
    @(negedge clk);
    byte_vld = 1'b1; byte_dc = dc; byte_val = v;
    @(posedge clk); #2;
    byte_vld = 1'b0;
    act = {ram_we, ram_re, rd_dummy, ram_col, ram_page, ram_wdata};
    exp = {ew, er, ed,
           (ew | er) ? CW'(ecol) : ram_col,
           (ew | er) ? PW'(epage) : ram_page,
           ew ? v : ram_wdata};
    check(tag, act, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; col_win_we = 0; page_win_we = 0; scan_we = 0;
    byte_vld = 0; byte_dc = 0; byte_val = 0;
    col_win_lo = 0; col_win_hi = 0; page_win_lo = 0; page_win_hi = 0; scan_cfg = 0;
    m_clo = 0; m_chi = 0; m_plo = 0; m_phi = 0; m_cc = 0; m_pc = 0;
    m_pf = 0; m_pm = 0; m_cm = 0; m_mode = 0; m_rs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset values at the ports
    check("R1", {ram_we, ram_re, rd_dummy, ram_col, ram_page, ram_wdata}, 25'd0);

    // R10: data before any stream command is ignored
    send(1'b1, 8'h11, "R10");
    send(1'b1, 8'h22, "R10");

    // R1/R3: default 0..0 window, writes stay at origin
    send(1'b0, 8'h5C, "R3");
    send(1'b1, 8'hA5, "R1");
    send(1'b1, 8'h5A, "R3");

    // R2: oversize bounds clamp
    set_col(40, 50);
    set_page(200, 250);
    send(1'b1, 8'h01, "R2");
    send(1'b1, 8'h02, "R2");

    // R4: column-first wrap over 3x2 window
    set_col(2, 4);
    set_page(5, 6);
    for (int i = 0; i < 8; i++) send(1'b1, 8'(i + 8'h30), "R4");

    // R5: page-first
    set_scan(1);
    set_col(2, 4);
    for (int i = 0; i < 8; i++) send(1'b1, 8'(i + 8'h40), "R5");

    // R6: mirrors, both scan orders
    set_scan(6);
    set_col(2, 4);
    set_page(5, 6);
    for (int i = 0; i < 7; i++) send(1'b1, 8'(i + 8'h50), "R6");
    set_scan(7);
    for (int i = 0; i < 7; i++) send(1'b1, 8'(i + 8'h60), "R6");
    set_scan(0);

    // R7: read stream, dummy then pairs
    set_col(10, 12);
    send(1'b0, 8'h5D, "R7");
    for (int i = 0; i < 7; i++) send(1'b1, 8'hFF, "R7");

    // R8: other command closes stream; new read restarts with dummy
    send(1'b0, 8'hAF, "R8");
    send(1'b1, 8'h77, "R8");
    send(1'b1, 8'h78, "R8");
    send(1'b0, 8'h5D, "R8");
    send(1'b1, 8'h00, "R8");
    send(1'b1, 8'h00, "R8");
    send(1'b0, 8'h5D, "R8");
    send(1'b1, 8'h00, "R8");

    // R9: window write reloads pointer
    send(1'b0, 8'h5C, "R9");
    send(1'b1, 8'h10, "R9");
    send(1'b1, 8'h11, "R9");
    set_col(20, 25);
    send(1'b1, 8'h12, "R9");
    set_page(100, 103);
    send(1'b1, 8'h13, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 4) begin
        int lo;
        lo = int'($urandom % 40);
        set_col(lo, lo + int'($urandom % 6));
      end else if (r < 8) begin
        int lo;
        lo = int'($urandom % 140);
        set_page(lo, lo + int'($urandom % 8));
      end else if (r < 12) begin
        set_scan(int'($urandom % 8));
      end else if (r < 22) begin
        int k;
        k = int'($urandom % 3);
        send(1'b0, (k == 0) ? 8'h5C : (k == 1) ? 8'h5D : 8'($urandom), "R8");
      end else begin
        send(1'b1, 8'($urandom),
             (m_mode == 1) ? "R3" : (m_mode == 2) ? "R7" : "R8");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule